// File: doc/BRIEF.md
# Display Memory Address Generator

This block drives the refresh address for a character-based display controller. A 16-bit address counter is reloaded from a programmed start value at the beginning of every displayed scan line. While display is active, it advances on character-clock enables at a selectable interval of one, two or four character clocks.

The counter value is then reorganized for byte, word or doubleword addressing. After that, two address bits may be replaced by the low bits of the row-scan count, and the result goes to the frame buffer address decoder as a combinational function of the counter register.

The block also produces the clock enable for the vertical timing counter. That enable is either each horizontal retrace pulse or every second one.

Top module: `fbag_top`

## Requirements
- R1: After synchronous reset the counter holds 0, so with both keep controls at 1 and byte addressing `fb_addr` reads 0x0000. With `hretrace` low, `vt_en` reads 0.
- R2: A cycle with `line_start` high loads `start_addr` into the counter, visible at `fb_addr` from the following cycle. The same cycle clears the interval prescaler.
- R3: The counter keeps its value in any cycle without `line_start` in which `disp_active` or `char_en` is 0. `fb_addr` is unchanged in the next cycle.
- R4: Counting character clocks (cycles with `char_en` and `disp_active` high and neither `line_start` nor `frame_start` high) from the last prescaler clear, the counter advances on every such clock in these cases:
  - `cnt_by2`=0 and `cnt_by4`=0: every clock.
  - `cnt_by2`=1: every 2nd clock, whatever `cnt_by4` is.
  - `cnt_by2`=0 and `cnt_by4`=1: every 4th clock.
- R5: Counter increments wrap modulo 2^16, so 0xFFFF advances to 0x0000.
- R6: The reorganized address depends on the addressing controls:
  - Byte addressing (`word_mode`=0, `dword_mode`=0): it equals the counter.
  - Word addressing: it is {cnt[14:0], cnt[13]}.
  - Doubleword addressing: it is {cnt[13:0], cnt[15:14]}.
  - `dword_mode` wins when both controls are 1.
- R7: After reorganization, row-scan bits replace two address bits:
  - `keep_a14`=0: bit 14 of `fb_addr` is replaced by `row_scan[1]`.
  - `keep_a13`=0: bit 13 of `fb_addr` is replaced by `row_scan[0]`.
  - A keep bit of 1 passes the reorganized bit through.
- R8: With `vdiv2`=0, `vt_en` equals `hretrace` in the same cycle. With `vdiv2`=1, `vt_en` is high only on the 2nd, 4th, 6th… `hretrace` pulse since the last reset or frame start.
- R9: `frame_start` clears both the interval prescaler and the retrace pulse parity, and blocks counting in its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | One-cycle start-of-frame strobe |
| line_start | input | 1 | One-cycle start of displayed scan line |
| disp_active | input | 1 | Display enable window |
| char_en | input | 1 | Character clock enable |
| hretrace | input | 1 | Horizontal retrace pulse (one cycle) |
| start_addr | input | 16 | Programmed start address |
| row_scan | input | 5 | Current row-scan count |
| cnt_by2 | input | 1 | Advance every 2 character clocks |
| cnt_by4 | input | 1 | Advance every 4 character clocks when cnt_by2 is 0 |
| word_mode | input | 1 | Word addressing reorganization |
| dword_mode | input | 1 | Doubleword addressing reorganization (priority) |
| keep_a14 | input | 1 | 0: bit 14 takes row_scan[1] |
| keep_a13 | input | 1 | 0: bit 13 takes row_scan[0] |
| vdiv2 | input | 1 | Halve the vertical timing enable |
| fb_addr | output | 16 | Frame buffer address |
| vt_en | output | 1 | Vertical timing counter enable |

## Verification
A wrong counter or prescaler state shows at `fb_addr` one cycle after the faulty edge. It persists until the next `line_start` reload, so any per-cycle comparison catches it within a scan line. A wrong retrace parity shows at `vt_en` on the very next `hretrace` pulse while halving is selected. Errors in reorganization or substitution are purely combinational and appear in the same cycle the controls select them. For that reason, every control combination is swept against a cycle-accurate reference model.

// File: rtl/fbag_pkg.sv
package fbag_pkg;

   typedef enum logic [1:0] {
      ORG_BYTE  = 2'd0,
      ORG_WORD  = 2'd1,
      ORG_DWORD = 2'd2
   } org_e;

   // doubleword beats word; neither means byte
   function automatic org_e org_pick(input logic word, input logic dword);
      if (dword)     return ORG_DWORD;
      else if (word) return ORG_WORD;
      else           return ORG_BYTE;
   endfunction

   // highest prescaler phase before an advance
   function automatic logic [1:0] last_phase(input logic by2, input logic by4);
      if (by2)      return 2'd1;
      else if (by4) return 2'd3;
      else          return 2'd0;
   endfunction

endpackage

// File: rtl/fbag_prescale.sv
module fbag_prescale
   import fbag_pkg::*;
#(
   parameter int PH_W = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic tick,
   input  logic by2,
   input  logic by4,
   output logic step
);
   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] lim;

   if (PH_W < 2) begin : g_bad_ph
      $error("fbag_prescale: PH_W must be at least 2");
   end

   assign lim  = PH_W'(last_phase(by2, by4));
   assign step = tick && (ph_q >= lim);

   always_ff @(posedge clk) begin
      if (rst || clr)
         ph_q <= '0;
      else if (tick)
         ph_q <= step ? '0 : ph_q + 1'b1;
   end

   // R9: a clear leaves the phase at zero
   a_r9_phase_clear: assert property (@(posedge clk) disable iff (rst)
      clr |=> (ph_q == '0));

endmodule

// File: rtl/fbag_addr_cnt.sv
module fbag_addr_cnt #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [AW-1:0] start,
   input  logic          step,
   output logic [AW-1:0] cnt
);
   logic [AW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= start;
      else if (step)
         cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;

   // R2: reload at line start
   a_r2_line_load: assert property (@(posedge clk) disable iff (rst)
      load |=> (cnt_q == $past(start)));

   // R3: no step, no load, no change
   a_r3_hold: assert property (@(posedge clk) disable iff (rst)
      (!load && !step) |=> $stable(cnt_q));

   // R5: all-ones wraps to zero
   a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
      (!load && step && (cnt_q == '1)) |=> (cnt_q == '0));

endmodule

// File: rtl/fbag_remap.sv
module fbag_remap
   import fbag_pkg::*;
#(
   parameter int AW       = 16,
   parameter int RS_W     = 5,
   parameter int WORD_SRC = 13,
   parameter int SUB_HI   = 14,
   parameter int SUB_LO   = 13
) (
   input  logic [AW-1:0]   cnt,
   input  logic            word_mode,
   input  logic            dword_mode,
   input  logic            keep_hi,
   input  logic            keep_lo,
   input  logic [RS_W-1:0] row_scan,
   output logic [AW-1:0]   addr
);
   logic [AW-1:0] word_v;
   logic [AW-1:0] dword_v;
   logic [AW-1:0] org_v;
   org_e          org;

   if (AW < 4 || SUB_HI >= AW || SUB_LO >= AW || SUB_HI == SUB_LO ||
       WORD_SRC >= AW || RS_W < 2) begin : g_bad_cfg
      $error("fbag_remap: inconsistent bit positions");
   end

   // rotated copies of the counter
   for (genvar i = 0; i < AW; i++) begin : g_rot
      if (i == 0) begin : g_w0
         assign word_v[i] = cnt[WORD_SRC];
      end else begin : g_wn
         assign word_v[i] = cnt[i-1];
      end
      assign dword_v[i] = cnt[(i + AW - 2) % AW];
   end

   assign org = org_pick(word_mode, dword_mode);

   always_comb begin
      unique case (org)
         ORG_WORD:  org_v = word_v;
         ORG_DWORD: org_v = dword_v;
         default:   org_v = cnt;
      endcase
   end

   // row-scan substitution after reorganization
   for (genvar i = 0; i < AW; i++) begin : g_sub
      if (i == SUB_HI) begin : g_hi
         assign addr[i] = keep_hi ? org_v[i] : row_scan[1];
      end else if (i == SUB_LO) begin : g_lo
         assign addr[i] = keep_lo ? org_v[i] : row_scan[0];
      end else begin : g_pass
         assign addr[i] = org_v[i];
      end
   end

   // R6: byte addressing with both keeps set is the identity
   a_r6_byte_ident: assert final (!(keep_hi && keep_lo && !word_mode && !dword_mode)
      || addr == cnt);

endmodule

// File: rtl/fbag_vdiv.sv
module fbag_vdiv (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic hretrace,
   input  logic div2,
   output logic vt_en
);
   logic par_q;

   always_ff @(posedge clk) begin
      if (rst || clr)
         par_q <= 1'b0;
      else if (hretrace)
         par_q <= ~par_q;
   end

   assign vt_en = hretrace && (!div2 || par_q);

   // R8: a suppressed pulse is followed by an enabled one
   a_r8_alternate: assert property (@(posedge clk) disable iff (rst)
      (div2 && hretrace && !vt_en && !clr) |=> (!(hretrace && div2) || vt_en));

   // R8: two enabled pulses never come back to back in halved mode
   a_r8_no_pair: assert property (@(posedge clk) disable iff (rst)
      (div2 && vt_en) |=> !(div2 && vt_en));

endmodule

// File: rtl/fbag_top.sv
module fbag_top #(
   parameter int AW       = 16,
   parameter int RS_W     = 5,
   parameter int WORD_SRC = 13,
   parameter int SUB_HI   = 14,
   parameter int SUB_LO   = 13
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            frame_start,
   input  logic            line_start,
   input  logic            disp_active,
   input  logic            char_en,
   input  logic            hretrace,
   input  logic [AW-1:0]   start_addr,
   input  logic [RS_W-1:0] row_scan,
   input  logic            cnt_by2,
   input  logic            cnt_by4,
   input  logic            word_mode,
   input  logic            dword_mode,
   input  logic            keep_a14,
   input  logic            keep_a13,
   input  logic            vdiv2,
   output logic [AW-1:0]   fb_addr,
   output logic            vt_en
);
   localparam int PH_W = 2;

   logic          tick;
   logic          step;
   logic [AW-1:0] cnt;

   assign tick = char_en && disp_active && !line_start && !frame_start;

   fbag_prescale #(.PH_W(PH_W)) i_pre (
      .clk  (clk),
      .rst  (rst),
      .clr  (frame_start || line_start),
      .tick (tick),
      .by2  (cnt_by2),
      .by4  (cnt_by4),
      .step (step)
   );

   fbag_addr_cnt #(.AW(AW)) i_cnt (
      .clk   (clk),
      .rst   (rst),
      .load  (line_start),
      .start (start_addr),
      .step  (step),
      .cnt   (cnt)
   );

   fbag_remap #(
      .AW(AW), .RS_W(RS_W), .WORD_SRC(WORD_SRC), .SUB_HI(SUB_HI), .SUB_LO(SUB_LO)
   ) i_remap (
      .cnt        (cnt),
      .word_mode  (word_mode),
      .dword_mode (dword_mode),
      .keep_hi    (keep_a14),
      .keep_lo    (keep_a13),
      .row_scan   (row_scan),
      .addr       (fb_addr)
   );

   fbag_vdiv i_vdiv (
      .clk      (clk),
      .rst      (rst),
      .clr      (frame_start),
      .hretrace (hretrace),
      .div2     (vdiv2),
      .vt_en    (vt_en)
   );

   // R4: unit interval advances on each qualifying character clock
   a_r4_by1_step: assert property (@(posedge clk) disable iff (rst)
      (tick && !cnt_by2 && !cnt_by4) |=> (cnt == AW'($past(cnt) + 1'b1)));

   // R3: display inactive freezes the counter
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!disp_active && !line_start) |=> $stable(cnt));

   // R4: the counter moves by at most one between reloads
   a_r4_small_step: assert property (@(posedge clk) disable iff (rst)
      !line_start |=> (cnt == $past(cnt) || cnt == AW'($past(cnt) + 1'b1)));

endmodule

// File: tb/test_fbag_top.sv
module test_fbag_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        frame_start, line_start, disp_active, char_en, hretrace;
   logic [15:0] start_addr;
   logic [4:0]  row_scan;
   logic        cnt_by2, cnt_by4, word_mode, dword_mode, keep_a14, keep_a13, vdiv2;
   logic [15:0] fb_addr;
   logic        vt_en;

   int n_run  = 0;
   int n_fail = 0;

   logic [15:0] m_cnt;
   logic [1:0]  m_ph;
   logic        m_par;

   always #2 clk = ~clk;

   fbag_top i_fbag_top (
      .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
      .disp_active(disp_active), .char_en(char_en), .hretrace(hretrace),
      .start_addr(start_addr), .row_scan(row_scan), .cnt_by2(cnt_by2),
      .cnt_by4(cnt_by4), .word_mode(word_mode), .dword_mode(dword_mode),
      .keep_a14(keep_a14), .keep_a13(keep_a13), .vdiv2(vdiv2),
      .fb_addr(fb_addr), .vt_en(vt_en)
   );

   function automatic logic [15:0] exp_addr(input logic [15:0] c);
      logic [15:0] r;
      if (dword_mode)     r = {c[13:0], c[15:14]};
      else if (word_mode) r = {c[14:0], c[13]};
      else                r = c;
      if (!keep_a14) r[14] = row_scan[1];
      if (!keep_a13) r[13] = row_scan[0];
      return r;
   endfunction

   task automatic check_out(input string rq);
      logic [15:0] ea;
      logic        ev;
      ea = exp_addr(m_cnt);
      ev = hretrace && (!vdiv2 || m_par);
      n_run++;
      if (fb_addr !== ea) begin
         n_fail++;
         $display("FAIL %s fb_addr actual %h expected %h", rq, fb_addr, ea);
      end
      n_run++;
      if (vt_en !== ev) begin
         n_fail++;
         $display("FAIL %s vt_en actual %b expected %b", rq, vt_en, ev);
      end
   endtask

   // called after the inputs of a cycle are settled, before its edge
   task automatic model_step();
      logic tk, st;
      logic [1:0] lim;
      tk  = char_en && disp_active && !line_start && !frame_start;
      lim = cnt_by2 ? 2'd1 : (cnt_by4 ? 2'd3 : 2'd0);
      st  = tk && (m_ph >= lim);
      if (frame_start || line_start) m_ph = 2'd0;
      else if (tk) m_ph = st ? 2'd0 : m_ph + 2'd1;
      if (line_start) m_cnt = start_addr;
      else if (st) m_cnt = m_cnt + 16'd1;
      if (frame_start) m_par = 1'b0;
      else if (hretrace) m_par = ~m_par;
   endtask

   task automatic cyc(input string rq);
      #1;
      check_out(rq);
      model_step();
      @(negedge clk);
   endtask

   task automatic idle_in();
      frame_start = 0; line_start = 0; disp_active = 0; char_en = 0; hretrace = 0;
   endtask

   task automatic set_ctl(input logic [6:0] c);
      {cnt_by2, cnt_by4, word_mode, dword_mode, keep_a14, keep_a13, vdiv2} = c;
   endtask

   initial begin
      #180000;
      n_fail++;
      $display("FAIL watchdog expired actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      rst = 1; idle_in(); start_addr = 0; row_scan = 0;
      set_ctl(7'b0000110);
      m_cnt = 0; m_ph = 0; m_par = 0;
      repeat (3) @(negedge clk);
      rst = 0;

      // R1: reset state
      cyc("R1");

      // R2: line load, then byte view
      line_start = 1; start_addr = 16'h1234; cyc("R2");
      line_start = 0; cyc("R2");

      // R3: inactive window holds even with char clocks
      char_en = 1; disp_active = 0; cyc("R3"); cyc("R3");

      // R4: by-4 interval, advance on the fourth tick only
      set_ctl(7'b0100110); disp_active = 1;
      for (int i = 0; i < 5; i++) cyc("R4");
      // R4: by-2 interval
      set_ctl(7'b1000110);
      for (int i = 0; i < 4; i++) cyc("R4");

      // R5: wrap
      set_ctl(7'b0000110);
      line_start = 1; start_addr = 16'hFFFF; cyc("R5");
      line_start = 0; cyc("R5"); cyc("R5");

      // R6: word and doubleword views, dword priority
      line_start = 1; start_addr = 16'hA5C3; char_en = 0; cyc("R6");
      line_start = 0;
      set_ctl(7'b0010110); cyc("R6");
      set_ctl(7'b0001110); cyc("R6");
      set_ctl(7'b0011110); cyc("R6");

      // R7: substitution of bits 14 and 13 after reorganization
      row_scan = 5'b00010; set_ctl(7'b0010000); cyc("R7");
      row_scan = 5'b00001; set_ctl(7'b0001010); cyc("R7");
      row_scan = 5'b11111; set_ctl(7'b0000100); cyc("R7");

      // R8: halved and plain retrace enable
      set_ctl(7'b0000111);
      for (int i = 0; i < 4; i++) begin hretrace = 1; cyc("R8"); hretrace = 0; cyc("R8"); end
      set_ctl(7'b0000110);
      hretrace = 1; cyc("R8"); hretrace = 0;

      // R9: frame start resets parity and prescaler
      set_ctl(7'b0100111);
      hretrace = 1; cyc("R9");
      hretrace = 0; frame_start = 1; cyc("R9");
      frame_start = 0; hretrace = 1; cyc("R9");
      hretrace = 1; cyc("R9"); hretrace = 0;
      char_en = 1; disp_active = 1; cyc("R9");
      frame_start = 1; cyc("R9"); frame_start = 0;
      for (int i = 0; i < 4; i++) cyc("R9");

      // every control combination with random traffic
      for (int c = 0; c < 128; c++) begin
         set_ctl(7'(c));
         for (int k = 0; k < 40; k++) begin
            line_start  = ($urandom % 16) == 0;
            frame_start = ($urandom % 64) == 0;
            disp_active = ($urandom % 8) != 0;
            char_en     = ($urandom % 4) != 0;
            hretrace    = ($urandom % 5) == 0;
            start_addr  = 16'($urandom);
            row_scan    = 5'($urandom);
            cyc("R4 R6 R7 R8");
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule